// File: doc/BRIEF.md
# Tripod Gait Quadrature Driver

This block generates the four square-wave drive lines for the leg actuators of a six-legged walker that moves with a tripod gait. A free-running clock at four times the actuator resonant frequency is divided by four to form two square waves of equal frequency. The second wave lags the first by one input clock, which is 90 degrees at the output frequency. One tripod receives this quadrature pair. The other tripod receives the exact bitwise inverse of the pair, because the three legs of each tripod move together and the two tripods move in opposition.

The legs return an asynchronous end-of-stroke pulse when the forward-moving legs reach full extent. Each pulse is synchronized and edge-detected, and then flips a tripod-select state. That flip inverts all four lines, so the motion of the two tripods trades over. A flip never restarts the divider. Every output comes straight from a flip-flop, so each line stays a clean square wave that changes only at clock edges. Away from a flip, each line changes no faster than the output frequency.

The block has no data stream. The feedback input and the four drive lines are plain control pins, with no valid/ready handshake and no back-pressure. Reset is synchronous and active high.

Top module: `tripod_gait_driver`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the outputs become out1a=0, out1b=0, out2a=1, out2b=1, and the divider and tripod-select state are cleared.
- R2: After reset is released, `out1a_o` is high after the 1st and 2nd clock edges and low after the 3rd and 4th clock edges. This repeats with a period of 4 clocks and a 50% duty cycle. The internal divider walks the Gray sequence 00, 01, 11, 10.
- R3: `out1b_o` follows the value `out1a_o` had one clock earlier, so it lags by one input clock, which is 90 degrees.
- R4: At every sample, `out2a_o` equals the inverse of `out1a_o` and `out2b_o` equals the inverse of `out1b_o`.
- R5: A rising edge on `leg_pulse_i` that arrives between clock edges n and n+1 inverts all four outputs from edge n+3 onward. The latency comes from a two-flop synchronizer, an edge detector and the output register.
- R6: A feedback pulse held high for many clocks causes exactly one inversion.
- R7: Pulses separated by a low level that spans at least one clock edge each cause one inversion. An inversion never restarts the divider: afterwards the outputs equal the uninverted sequence, inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock at four times the actuator frequency |
| rst_i | input | 1 | Synchronous reset, active high |
| leg_pulse_i | input | 1 | Asynchronous end-of-stroke pulse from the legs |
| out1a_o | output | 1 | Tripod 1, leading phase |
| out1b_o | output | 1 | Tripod 1, lagging phase |
| out2a_o | output | 1 | Tripod 2, inverse of the leading phase |
| out2b_o | output | 1 | Tripod 2, inverse of the lagging phase |

## Verification
After a reset or divider step that a clock edge applies, the new output values are due within that same edge, so the bench checks them at the following falling edge. An end-of-stroke rise driven between edges n and n+1 is due at edge n+3. The driver task schedules the inversion for exactly that edge in its model and pushes one expected item per edge into the queue. The monitor pops one item on each falling edge, so a one-cycle slip in the divider, the lag or the swap shows up as a mismatch.

// File: rtl/tgd_pkg.sv
package tgd_pkg;

  // Gray-coded divide-by-four phase; one bit changes per step
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_RISE = 2'b01,
    PH_HIGH = 2'b11,
    PH_FALL = 2'b10
  } phase_e;

  typedef struct packed {
    logic lead;
    logic lag;
  } drive_pair_t;

  localparam int unsigned TRIPODS = 2;

  function automatic phase_e phase_step(input phase_e cur);
    case (cur)
      PH_IDLE: phase_step = PH_RISE;
      PH_RISE: phase_step = PH_HIGH;
      PH_HIGH: phase_step = PH_FALL;
      default: phase_step = PH_IDLE;
    endcase
  endfunction

  // leading line is high in the two phases after leaving idle
  function automatic logic lead_level(input phase_e ph);
    lead_level = (ph == PH_RISE) || (ph == PH_HIGH);
  endfunction

  // lagging line is high one phase later
  function automatic logic lag_level(input phase_e ph);
    lag_level = (ph == PH_HIGH) || (ph == PH_FALL);
  endfunction

endpackage

// File: rtl/tgd_edge_sync.sv
module tgd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic rise_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          last_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q[0] <= async_i;
      last_q     <= chain_q[LAST];
    end
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i) begin
        if (rst_i) chain_q[s] <= 1'b0;
        else       chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign rise_o = chain_q[LAST] & ~last_q;

endmodule

// File: rtl/tgd_phase_ctr.sv
module tgd_phase_ctr
  import tgd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  output phase_e phase_nxt_o
);

  phase_e phase_q;

  assign phase_nxt_o = rst_i ? PH_IDLE : phase_step(phase_q);

  always_ff @(posedge clk_i) begin
    phase_q <= phase_nxt_o;
  end

endmodule

// File: rtl/tgd_drive_regs.sv
module tgd_drive_regs
  import tgd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  phase_e      phase_nxt_i,
  input  logic        swap_nxt_i,
  output drive_pair_t pair_o [TRIPODS]
);

  drive_pair_t base;

  always_comb begin
    base.lead = lead_level(phase_nxt_i);
    base.lag  = lag_level(phase_nxt_i);
  end

  generate
    for (genvar t = 0; t < TRIPODS; t++) begin : g_tripod
      localparam logic OPPOSE = (t % 2 == 1);
      drive_pair_t pair_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          pair_q <= OPPOSE ? 2'b11 : 2'b00;
        end else begin
          pair_q <= base ^ {2{swap_nxt_i ^ OPPOSE}};
        end
      end
      assign pair_o[t] = pair_q;
    end
  endgenerate

endmodule

// File: rtl/tripod_gait_driver.sv
module tripod_gait_driver
  import tgd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic leg_pulse_i,
  output logic out1a_o,
  output logic out1b_o,
  output logic out2a_o,
  output logic out2b_o
);

  logic        swap_tog;
  logic        swap_q;
  logic        swap_nxt;
  phase_e      phase_nxt;
  drive_pair_t pairs [TRIPODS];

  tgd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .async_i (leg_pulse_i),
    .rise_o  (swap_tog)
  );

  tgd_phase_ctr u_ctr (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .phase_nxt_o (phase_nxt)
  );

  assign swap_nxt = swap_q ^ swap_tog;

  always_ff @(posedge clk_i) begin
    if (rst_i) swap_q <= 1'b0;
    else       swap_q <= swap_nxt;
  end

  tgd_drive_regs u_drv (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .phase_nxt_i (phase_nxt),
    .swap_nxt_i  (swap_nxt),
    .pair_o      (pairs)
  );

  assign out1a_o = pairs[0].lead;
  assign out1b_o = pairs[0].lag;
  assign out2a_o = pairs[1].lead;
  assign out2b_o = pairs[1].lag;

endmodule

// File: rtl/tgd_checker.sv
module tgd_checker (
  input logic clk_i,
  input logic rst_i,
  input logic tog_i,
  input logic out1a_o,
  input logic out1b_o,
  input logic out2a_o,
  input logic out2b_o
);

  // R4
  pair_a_inverse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    out2a_o == !out1a_o);

  // R4
  pair_b_inverse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    out2b_o == !out1b_o);

  // R3
  quarter_lag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !tog_i |=> (out1b_o == $past(out1a_o)));

  // R2
  half_period_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!tog_i && !$past(tog_i) && !$past(rst_i) && (out1a_o != $past(out1a_o)))
      |=> $stable(out1a_o));

  // R6
  single_toggle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    tog_i |=> !tog_i);

endmodule

bind tripod_gait_driver tgd_checker u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .tog_i   (swap_tog),
  .out1a_o (out1a_o),
  .out1b_o (out1b_o),
  .out2a_o (out2a_o),
  .out2b_o (out2b_o)
);

// File: tb/tripod_gait_driver_test.sv
module tripod_gait_driver_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_i = 1'b1;
  logic leg_pulse_i = 1'b0;
  logic out1a_o, out1b_o, out2a_o, out2b_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [3:0] exp_q [$];
  string      tag_q [$];
  int         toggle_at [$];

  int    edge_cnt = 0;
  int    idx = 0;
  bit    inv = 0;
  bit    prev_leg = 0;
  string scen = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tripod_gait_driver uut (
    .clk_i       (clk),
    .rst_i       (rst_i),
    .leg_pulse_i (leg_pulse_i),
    .out1a_o     (out1a_o),
    .out1b_o     (out1b_o),
    .out2a_o     (out2a_o),
    .out2b_o     (out2b_o)
  );

  task automatic check_bit(input string tag, input string name,
                           input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at edge %0d",
               tag, name, act, exp, edge_cnt);
    end
  endtask

  // Driver: called just after a rising edge; drives inputs and predicts next edge
  task automatic tick(input bit rst_v, input bit leg_v);
    logic a, b;
    rst_i = rst_v;
    leg_pulse_i = leg_v;
    if (!rst_v && leg_v && !prev_leg)
      toggle_at.push_back(edge_cnt + 3);   // R5 latency: edge n+3
    prev_leg = leg_v;
    @(posedge clk);
    edge_cnt++;
    if (rst_v) begin
      idx = 0;
      inv = 0;
      toggle_at.delete();
    end else begin
      idx = (idx + 1) % 4;
      for (int k = 0; k < toggle_at.size(); k++)
        if (toggle_at[k] == edge_cnt) inv = ~inv;
    end
    a = ((idx == 1) || (idx == 2)) ^ inv;
    b = ((idx == 2) || (idx == 3)) ^ inv;
    exp_q.push_back({a, b, ~a, ~b});
    tag_q.push_back(scen);
    #1;
  endtask

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check_bit(t, "out1a", out1a_o, e[3]);
      check_bit((t == "R1") ? t : "R3", "out1b", out1b_o, e[2]);
      check_bit((t == "R1") ? t : "R4", "out2a", out2a_o, e[1]);
      check_bit((t == "R1") ? t : "R4", "out2b", out2b_o, e[0]);
    end
  end

  initial begin
    // R1: reset state
    scen = "R1";
    repeat (3) tick(1, 0);
    // R2: free running divider
    scen = "R2";
    repeat (12) tick(0, 0);
    // R5: one short pulse, inversion at edge n+3
    scen = "R5";
    repeat (2) tick(0, 1);
    repeat (10) tick(0, 0);
    // R6: long pulse, single inversion
    scen = "R6";
    repeat (9) tick(0, 1);
    repeat (8) tick(0, 0);
    // R7: closely spaced pulses, divider keeps running
    scen = "R7";
    repeat (2) tick(0, 1);
    tick(0, 0);
    repeat (2) tick(0, 1);
    tick(0, 0);
    repeat (2) tick(0, 1);
    repeat (9) tick(0, 0);
    // R1: reset in mid-run clears swap and divider
    scen = "R1";
    repeat (2) tick(1, 0);
    scen = "R2";
    repeat (8) tick(0, 0);
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule